// File: doc/BRIEF.md
# Serial EEPROM Command and Status Front-End

This block is the slave side of a small serial memory. It sits on a four-wire serial bus in mode 0: the clock idles low, input bits are sampled on the rising clock edge and output bits change on the falling edge. It decodes one-byte instructions and acts on an internal byte array and an 8-bit status register. Every field crosses the bus most significant bit first, and each command begins when chip select goes low.

The bus pins are sampled through synchronizers in the system clock domain. Reads and status reads answer on the output pin from the byte after the opcode, or after the address. Writes and status writes are collected while chip select is low. A write is carried out by a counted internal cycle that starts when chip select goes high. While that cycle runs, the status register shows busy and only status reads are honoured. A two-bit block-protect field fences off an upper part of the array. An active-low protect pin, together with a status enable bit, locks the status register against writes.

Top module: `sermem_front`

## Requirements
- R1: Bus mode 0. MOSI is sampled on the rising SCK edge and MISO changes on the falling edge, MSB first. MISO is 0 whenever chip select is high.
- R2: An opcode byte is honoured only when bits 7:4 are 0000. Bit 3 is ignored. Bits 2:0 select: 110 enable writes, 100 disable writes, 101 read status, 001 write status, 011 read array, 010 write array. Any other byte is ignored.
- R3: After reset every status bit is 0. The enable command sets the write-enable bit and the disable command clears it.
- R4: A status read returns, for every byte clocked out, {bit7 protect-enable, bits6:4 reserved, bits3:2 block-protect, bit1 write-enable, bit0 busy}.
- R5: While no internal cycle runs, bits 6:4 and bit 0 read 0. During an internal cycle they read 1.
- R6: A status write needs write-enable = 1 and one full data byte. It copies data bits 7 and 3:2 only, and then starts an internal cycle.
- R7: A status write is ignored when protect-enable = 1 and the WP_n pin is low.
- R8: An array write needs write-enable = 1, a 16-bit address of which only the low ADDR_W bits are used, and at least one full data byte. Its data appears in the array after an internal cycle of exactly WR_CYCLES clocks, which starts on chip-select release. Write-enable clears when the cycle ends.
- R9: Block-protect 00 protects nothing, 01 the top quarter, 10 the top half and 11 the whole array. An array write whose start address is protected is ignored and starts no cycle.
- R10: Array write data fills successive addresses and wraps inside its 2^PAGE_W-byte page.
- R11: An array read returns successive bytes and wraps from the last address to address 0.
- R12: During an internal cycle, every command except the status read is ignored. A read returns zeros and the disable command leaves write-enable set.
- R13: A write command released before any complete data byte, or with a trailing partial byte only, starts no cycle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial bus clock |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| wp_n | input | 1 | Active-low status write lock pin |

## Verification
Each bus input reaches the logic three system clocks after it changes, through two synchronizer stages and one edge register. A response bit is therefore on MISO about four clocks after the falling SCK edge. The bench holds each SCK phase for eight clocks and samples MISO just before the next rising edge. Status changes from enable and disable commands are visible in the very next command. An internal cycle begins about three clocks after chip select rises and lasts exactly WR_CYCLES clocks. The bench reads busy status well inside that window and waits WR_CYCLES plus a margin before it expects idle status or committed data. The exact cycle length is checked by a counter in the checker.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } op_e;

  typedef enum logic [2:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_DATA, PH_SKIP
  } phase_e;

  // opcode decode: upper nibble must be zero, bit 3 is a don't-care
  function automatic op_e decode_op(input logic [7:0] b);
    op_e r;
    r = OP_NONE;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  r = OP_WREN;
        3'b100:  r = OP_WRDI;
        3'b101:  r = OP_RDSR;
        3'b001:  r = OP_WRSR;
        3'b011:  r = OP_READ;
        3'b010:  r = OP_WRITE;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

  // block protection of the upper part of a 2^aw array
  function automatic logic in_protected(input logic [15:0] a, input int aw,
                                        input logic [1:0] bp);
    logic [15:0] top;
    top = a >> (aw - 2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top[1:0] == 2'b11;
      2'b10:   return top[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic wpen, input logic [1:0] bp,
                                             input logic wel, input logic busy);
    return {wpen, {3{busy}}, bp, wel, busy};
  endfunction

  function automatic logic [15:0] next_read_addr(input logic [15:0] a, input int aw);
    logic [15:0] m;
    m = 16'((32'd1 << aw) - 32'd1);
    return (a + 16'd1) & m;
  endfunction

  function automatic logic [15:0] next_page_addr(input logic [15:0] a, input int pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/sermem_spi_phy.sv
module sermem_spi_phy #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       wp_n,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  output logic       cs_act,
  output logic       cs_start,
  output logic       cs_end,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       wp_n_s,
  output logic       miso
);
  // bundle order {wp_n, mosi, sck, cs_n}
  localparam logic [3:0] SYNC_RST = 4'b1001;

  logic [3:0] stage [SYNC];
  logic [3:0] synced;
  logic       cs_q, sck_q;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= SYNC_RST;
    else        stage[0] <= {wp_n, mosi, sck, cs_n};
  end

  for (genvar k = 1; k < SYNC; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[k] <= SYNC_RST;
      else        stage[k] <= stage[k-1];
    end
  end

  assign synced = stage[SYNC-1];
  assign wp_n_s = synced[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= synced[0];
      sck_q <= synced[1];
    end
  end

  assign cs_act   = !synced[0];
  assign cs_start = cs_q && !synced[0];
  assign cs_end   = !cs_q && synced[0];
  assign sck_rise = cs_act && !sck_q && synced[1];
  assign sck_fall = cs_act && sck_q && !synced[1];

  // receive path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_act || cs_start) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], synced[2]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_byte  <= {shreg, synced[2]};
        end
      end
    end
  end

  // transmit path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (!cs_act) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (tx_load) begin
      tx_sr <= tx_data;
    end else if (sck_fall) begin
      miso  <= tx_sr[7];
      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sermem_page_buf.sv
module sermem_page_buf #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] ridx,
  output logic          rvalid,
  output logic [7:0]    rdata
);
  localparam int PAGE = 1 << PW;

  logic [7:0]      data [PAGE];
  logic [PAGE-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld <= '0;
    else if (clear)  vld <= '0;
    else if (we)     vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) data[widx] <= wdata;
  end

  assign rvalid = vld[ridx];
  assign rdata  = data[ridx];

endmodule

// File: rtl/sermem_cmd_ctrl.sv
module sermem_cmd_ctrl
  import sermem_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PW        = 6,
  parameter int WR_CYCLES = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_start,
  input  logic          cs_end,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          wp_n_s,
  output logic          tx_load,
  output logic [7:0]    tx_data,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          buf_clear,
  output logic          buf_we,
  output logic [PW-1:0] buf_widx,
  output logic [7:0]    buf_wdata,
  output logic [PW-1:0] buf_ridx,
  input  logic          buf_rvalid,
  input  logic [7:0]    buf_rdata,
  output logic          wpen,
  output logic [1:0]    bp,
  output logic          wel,
  output logic          busy,
  output logic          wr_start,
  output logic          wr_done,
  output logic          wrsr_apply
);
  localparam int CW   = $clog2(WR_CYCLES + 1);
  localparam int PAGE = 1 << PW;

  phase_e        phase_q;
  op_e           op_q, op_dec, op_eff;
  logic [7:0]    addr_hi_q, wrsr_q;
  logic [AW-1:0] ptr_q, start_q, addr_lo;
  logic [AW-1:0] ptr_rd_nx, ptr_pg_nx, lo_rd_nx;
  logic          seen_q, commit_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    status_byte;
  logic          wr_ok, wrsr_ok, in_commit;
  logic [15:0]   addr_full;

  assign op_dec      = decode_op(rx_byte);
  assign op_eff      = (busy && op_dec != OP_RDSR) ? OP_NONE : op_dec;
  assign addr_full   = {addr_hi_q, rx_byte};
  assign addr_lo     = AW'(addr_full);
  assign ptr_rd_nx   = AW'(next_read_addr(16'(ptr_q), AW));
  assign lo_rd_nx    = AW'(next_read_addr(16'(addr_lo), AW));
  assign ptr_pg_nx   = AW'(next_page_addr(16'(ptr_q), PW));
  assign status_byte = pack_status(wpen, bp, wel, busy);

  // array read address: the low address byte selects the first read byte
  always_comb begin
    mem_raddr = ptr_q;
    if (phase_q == PH_ALO) mem_raddr = addr_lo;
  end

  // response byte for the transmit path
  always_comb begin
    tx_load = 1'b0;
    tx_data = status_byte;
    if (rx_valid) begin
      case (phase_q)
        PH_OPC:  tx_load = (op_eff == OP_RDSR);
        PH_ALO:  if (op_q == OP_READ) begin
                   tx_load = 1'b1;
                   tx_data = mem_rdata;
                 end
        PH_DATA: if (op_q == OP_RDSR) begin
                   tx_load = 1'b1;
                 end else if (op_q == OP_READ) begin
                   tx_load = 1'b1;
                   tx_data = mem_rdata;
                 end
        default: tx_load = 1'b0;
      endcase
    end
  end

  // end-of-command qualification
  assign wr_ok      = (op_q == OP_WRITE) && seen_q && wel &&
                      !in_protected(16'(start_q), AW, bp);
  assign wrsr_ok    = (op_q == OP_WRSR) && seen_q && wel && !(wpen && !wp_n_s);
  assign wr_start   = cs_end && (wr_ok || wrsr_ok);
  assign wrsr_apply = cs_end && wrsr_ok;
  assign wr_done    = busy && (cnt_q == CW'(WR_CYCLES - 1));

  // page buffer fill
  assign buf_clear = (rx_valid && phase_q == PH_OPC && op_eff == OP_WRITE) || wr_done;
  assign buf_we    = rx_valid && phase_q == PH_DATA && op_q == OP_WRITE;
  assign buf_widx  = ptr_q[PW-1:0];
  assign buf_wdata = rx_byte;

  // commit of buffered bytes during the internal cycle
  assign in_commit = busy && commit_q && (cnt_q < CW'(PAGE));
  assign buf_ridx  = cnt_q[PW-1:0];
  assign mem_we    = in_commit && buf_rvalid;
  assign mem_waddr = {start_q[AW-1:PW], cnt_q[PW-1:0]};
  assign mem_wdata = buf_rdata;

  // command sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_SKIP;
      op_q      <= OP_NONE;
      addr_hi_q <= '0;
      wrsr_q    <= '0;
      ptr_q     <= '0;
      start_q   <= '0;
      seen_q    <= 1'b0;
    end else if (cs_start) begin
      phase_q <= PH_OPC;
      op_q    <= OP_NONE;
      seen_q  <= 1'b0;
    end else if (cs_end) begin
      phase_q <= PH_SKIP;
      op_q    <= OP_NONE;
      seen_q  <= 1'b0;
    end else if (rx_valid) begin
      case (phase_q)
        PH_OPC: begin
          op_q <= op_eff;
          case (op_eff)
            OP_RDSR, OP_WRSR:  phase_q <= PH_DATA;
            OP_READ, OP_WRITE: phase_q <= PH_AHI;
            default:           phase_q <= PH_SKIP;
          endcase
        end
        PH_AHI: begin
          addr_hi_q <= rx_byte;
          phase_q   <= PH_ALO;
        end
        PH_ALO: begin
          phase_q <= PH_DATA;
          if (op_q == OP_READ) begin
            ptr_q <= lo_rd_nx;
          end else begin
            ptr_q   <= addr_lo;
            start_q <= addr_lo;
          end
        end
        PH_DATA: begin
          case (op_q)
            OP_READ:  ptr_q <= ptr_rd_nx;
            OP_WRITE: begin
              ptr_q  <= ptr_pg_nx;
              seen_q <= 1'b1;
            end
            OP_WRSR: begin
              wrsr_q <= rx_byte;
              seen_q <= 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // status register and internal write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen     <= 1'b0;
      bp       <= 2'b00;
      wel      <= 1'b0;
      busy     <= 1'b0;
      commit_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (rx_valid && phase_q == PH_OPC) begin
        if (op_eff == OP_WREN) wel <= 1'b1;
        if (op_eff == OP_WRDI) wel <= 1'b0;
      end
      if (wrsr_apply) begin
        wpen <= wrsr_q[7];
        bp   <= wrsr_q[3:2];
      end
      if (wr_start) begin
        busy     <= 1'b1;
        commit_q <= wr_ok;
        cnt_q    <= '0;
      end else if (wr_done) begin
        busy     <= 1'b0;
        commit_q <= 1'b0;
        wel      <= 1'b0;
        cnt_q    <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/sermem_front.sv
module sermem_front #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 6,
  parameter int WR_CYCLES   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  input  logic wp_n
);
  // named internal events, also observed by the bound checker
  logic              cs_act, cs_start, cs_end;
  logic              rx_valid;
  logic [7:0]        rx_byte;
  logic              wp_n_s;
  logic              tx_load;
  logic [7:0]        tx_data;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [7:0]        mem_rdata, mem_wdata;
  logic              mem_we;
  logic              buf_clear, buf_we, buf_rvalid;
  logic [PAGE_W-1:0] buf_widx, buf_ridx;
  logic [7:0]        buf_wdata, buf_rdata;
  logic              wpen, wel, busy;
  logic [1:0]        bp;
  logic              wr_start, wr_done, wrsr_apply;

  sermem_spi_phy #(.SYNC(SYNC_STAGES)) u_phy (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
    .tx_load(tx_load), .tx_data(tx_data),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .wp_n_s(wp_n_s), .miso(miso)
  );

  sermem_cmd_ctrl #(.AW(ADDR_W), .PW(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .cs_end(cs_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .wp_n_s(wp_n_s),
    .tx_load(tx_load), .tx_data(tx_data),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .buf_clear(buf_clear), .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .buf_ridx(buf_ridx), .buf_rvalid(buf_rvalid), .buf_rdata(buf_rdata),
    .wpen(wpen), .bp(bp), .wel(wel), .busy(busy),
    .wr_start(wr_start), .wr_done(wr_done), .wrsr_apply(wrsr_apply)
  );

  sermem_page_buf #(.PW(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .we(buf_we), .widx(buf_widx),
    .wdata(buf_wdata), .ridx(buf_ridx), .rvalid(buf_rvalid), .rdata(buf_rdata)
  );

  sermem_array #(.AW(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

endmodule

// File: rtl/sermem_front_chk.sv
module sermem_front_chk
  import sermem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              miso,
  input logic              wel,
  input logic              busy,
  input logic              wpen,
  input logic [1:0]        bp,
  input logic              wp_n_s,
  input logic              wr_start,
  input logic              wr_done,
  input logic              wrsr_apply,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= '0;
  end

  assert_miso_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);

  assert_wrsr_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_apply |-> !(wpen && !wp_n_s));

  assert_wrsr_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_apply |=> busy);

  assert_start_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (wel && !busy));

  assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (!wel && !busy));

  assert_cycle_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (busy_len == 32'(WR_CYCLES)));

  assert_write_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_write_unprotected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_protected(16'(mem_waddr), ADDR_W, bp));

endmodule

bind sermem_front sermem_front_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso(miso), .wel(wel), .busy(busy),
  .wpen(wpen), .bp(bp), .wp_n_s(wp_n_s), .wr_start(wr_start), .wr_done(wr_done),
  .wrsr_apply(wrsr_apply), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/sermem_front_bench.sv
`timescale 1ns/1ps
module sermem_front_bench;
  localparam int WR = 2000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sermem_front #(.ADDR_W(8), .PAGE_W(6), .WR_CYCLES(WR), .SYNC_STAGES(2)) u_sermem_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .wp_n(wp_n)
  );

  function automatic logic [7:0] exp_sr(input logic wpen, input logic [1:0] bp,
                                        input logic wel, input logic bsy);
    logic [7:0] s;
    s = 8'h00;
    s[7] = wpen;
    s[3:2] = bp;
    s[1] = wel;
    if (bsy) s = s | 8'h71;
    return s;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input int n, input logic [7:0] din, output logic [7:0] dout);
    dout = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosi = din[7-i];
      repeat (HALF) @(negedge clk);
      dout = {dout[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic spi_begin();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    spi_begin();
    spi_bits(8, op, d);
    spi_end();
  endtask

  task automatic rdsr2(output logic [7:0] s0, output logic [7:0] s1);
    logic [7:0] d;
    spi_begin();
    spi_bits(8, 8'h05, d);
    spi_bits(8, 8'h00, s0);
    spi_bits(8, 8'h00, s1);
    spi_end();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    spi_begin();
    spi_bits(8, 8'h01, d);
    spi_bits(8, v, d);
    spi_end();
  endtask

  task automatic write_mem(input logic [15:0] a, input int n, input logic [31:0] data);
    logic [7:0] d;
    spi_begin();
    spi_bits(8, 8'h02, d);
    spi_bits(8, a[15:8], d);
    spi_bits(8, a[7:0], d);
    for (int i = 0; i < n; i++) spi_bits(8, data[31-8*i -: 8], d);
    spi_end();
  endtask

  task automatic read_mem(input logic [15:0] a, input int n, output logic [31:0] q);
    logic [7:0] d;
    q = 32'h0;
    spi_begin();
    spi_bits(8, 8'h03, d);
    spi_bits(8, a[15:8], d);
    spi_bits(8, a[7:0], d);
    for (int i = 0; i < n; i++) begin
      spi_bits(8, 8'h00, d);
      q[31-8*i -: 8] = d;
    end
    spi_end();
  endtask

  task automatic wait_cycle();
    repeat (WR + 100) @(negedge clk);
  endtask

  task automatic t_reset_and_enable();
    logic [7:0] s0, s1;
    rdsr2(s0, s1);
    check8("R3 reset status", s0, exp_sr(0, 2'b00, 0, 0));
    cmd1(8'h16);
    rdsr2(s0, s1);
    check8("R2 nonzero upper nibble ignored", s0, exp_sr(0, 2'b00, 0, 0));
    cmd1(8'h0E);
    rdsr2(s0, s1);
    check8("R2 enable with bit3 set", s0, exp_sr(0, 2'b00, 1, 0));
    check8("R4 status repeats", s1, exp_sr(0, 2'b00, 1, 0));
    cmd1(8'h04);
    rdsr2(s0, s1);
    check8("R3 disable clears", s0, exp_sr(0, 2'b00, 0, 0));
  endtask

  task automatic t_status_write();
    logic [7:0] s0, s1;
    wrsr(8'h8C);
    rdsr2(s0, s1);
    check8("R6 status write without enable", s0, exp_sr(0, 2'b00, 0, 0));
    cmd1(8'h06);
    wrsr(8'hFF);
    rdsr2(s0, s1);
    check8("R5 busy status", s0, exp_sr(1, 2'b11, 1, 1));
    wait_cycle();
    rdsr2(s0, s1);
    check8("R6 only bits 7 3 2 kept and R8 enable cleared", s0, exp_sr(1, 2'b11, 0, 0));
  endtask

  task automatic t_wp_lock();
    logic [7:0] s0, s1;
    wp_n = 1'b0;
    cmd1(8'h06);
    wrsr(8'h00);
    rdsr2(s0, s1);
    check8("R7 locked status write", s0, exp_sr(1, 2'b11, 1, 0));
    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    wrsr(8'h04);
    wait_cycle();
    rdsr2(s0, s1);
    check8("R6 status write after unlock", s0, exp_sr(0, 2'b01, 0, 0));
  endtask

  task automatic t_protect_and_page();
    logic [7:0] s0, s1;
    logic [31:0] q;
    cmd1(8'h06);
    write_mem(16'h00C5, 1, 32'h5500_0000);
    rdsr2(s0, s1);
    check8("R9 quarter protected write no cycle", s0, exp_sr(0, 2'b01, 1, 0));
    read_mem(16'h00C5, 1, q);
    check8("R9 protected byte unchanged", q[31:24], 8'h00);
    write_mem(16'h1240, 1, 32'h3C00_0000);
    wait_cycle();
    read_mem(16'h0040, 1, q);
    check8("R8 written byte with upper address bits ignored", q[31:24], 8'h3C);
    cmd1(8'h06);
    wrsr(8'h08);
    wait_cycle();
    cmd1(8'h06);
    write_mem(16'h0080, 1, 32'h9900_0000);
    rdsr2(s0, s1);
    check8("R9 half protected write no cycle", s0, exp_sr(0, 2'b10, 1, 0));
    write_mem(16'h007E, 4, 32'hA1B2_C3D4);
    wait_cycle();
    read_mem(16'h007E, 2, q);
    check8("R10 page first byte", q[31:24], 8'hA1);
    check8("R10 page second byte", q[23:16], 8'hB2);
    read_mem(16'h0040, 2, q);
    check8("R10 wrapped byte at page start", q[31:24], 8'hC3);
    check8("R10 wrapped second byte", q[23:16], 8'hD4);
    read_mem(16'h0080, 1, q);
    check8("R9 half protected byte unchanged", q[31:24], 8'h00);
  endtask

  task automatic t_busy_and_wrap();
    logic [7:0] s0, s1;
    logic [31:0] q;
    cmd1(8'h06);
    wrsr(8'h00);
    wait_cycle();
    cmd1(8'h06);
    write_mem(16'h0000, 2, 32'h1122_0000);
    read_mem(16'h0000, 1, q);
    check8("R12 read during cycle returns zero", q[31:24], 8'h00);
    cmd1(8'h04);
    rdsr2(s0, s1);
    check8("R12 disable ignored during cycle and R5 busy bits", s0, exp_sr(0, 2'b00, 1, 1));
    wait_cycle();
    rdsr2(s0, s1);
    check8("R8 idle after cycle", s0, exp_sr(0, 2'b00, 0, 0));
    read_mem(16'h00FE, 4, q);
    check8("R11 byte at FE", q[31:24], 8'h00);
    check8("R11 byte at FF", q[23:16], 8'h00);
    check8("R11 wrapped to 00 and R1 order", q[15:8], 8'h11);
    check8("R11 byte at 01", q[7:0], 8'h22);
  endtask

  task automatic t_partial();
    logic [7:0] s0, s1, d;
    logic [31:0] q;
    cmd1(8'h06);
    spi_begin();
    spi_bits(8, 8'h02, d);
    spi_bits(8, 8'h00, d);
    spi_bits(8, 8'h10, d);
    spi_bits(5, 8'hFF, d);
    spi_end();
    rdsr2(s0, s1);
    check8("R13 partial data byte starts no cycle", s0, exp_sr(0, 2'b00, 1, 0));
    read_mem(16'h0010, 1, q);
    check8("R13 array unchanged", q[31:24], 8'h00);
    cmd1(8'h01);
    rdsr2(s0, s1);
    check8("R13 status write without data", s0, exp_sr(0, 2'b00, 1, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_and_enable();
    t_status_write();
    t_wp_lock();
    t_protect_and_page();
    t_busy_and_wrap();
    t_partial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule